// File: doc/BRIEF.md
# Triple-Buffer Frame Rotation Controller

This block keeps three equal frame buffers and moves each of them through three roles in turn. The capture role collects an incoming sample stream one word at a time. The work role is open to a frame processor through a random read/write port. The playback role is read out in order to a downstream consumer with a valid/ready handshake. The samples arrive as 32-bit words. Only the upper 16-bit half is kept, as a signed Q15 value; the lower half is dropped.

When the capture buffer takes its last sample, all three roles change on the same clock edge. The filled frame goes to the processor. The processed frame goes to playback. The buffer that has just been played back starts collecting the next frame. Each rotation issues one start pulse to the processor. If a rotation comes before the processor has answered the previous start, a sticky overrun flag is raised, and the rotation takes place anyway.

Top module: `tribuf_rotator`

## Requirements
- R1: After reset, the capture select is 0, the work select is 1 and the playback select is 2. Every buffer word reads as zero, `proc_start` and `overrun` are low, `out_valid` is low and `wr_addr` is 0.
- R2: On a rotation, the new capture select takes the old playback select, the new work select takes the old capture select, and the new playback select takes the old work select. The three 2-bit selects always hold the distinct values 0, 1 and 2, and they change only on a rotation.
- R3: `wr_addr` advances by one on each cycle with `in_valid` high and holds otherwise. On the accepted sample at address FRAME_LEN-1 it returns to 0, and that same clock edge performs the rotation.
- R4: An accepted sample stores `in_data[31:16]` at `wr_addr` of the capture buffer; `in_data[15:0]` is discarded.
- R5: `proc_rdata` shows the word of the work buffer at `proc_addr` combinationally, and `proc_we` writes `proc_wdata` there. Incoming samples never alter the work buffer.
- R6: `proc_start` is high for exactly the one cycle after each rotation edge, and is low at all other times.
- R7: After each rotation, `out_valid` rises with `out_addr` at 0. `out_data` presents playback-buffer word `out_addr`, and the address advances only on a cycle with `out_valid` and `out_ready` both high. After the handshake on word FRAME_LEN-1, `out_valid` stays low until the next rotation. A rotation restarts playback at word 0.
- R8: `overrun` is set when a rotation occurs while a start is still unanswered by `proc_done`, and only reset clears it. A `proc_done` in the same cycle as the rotation counts as an answer in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Incoming sample strobe |
| in_data | input | 32 | Incoming sample word; upper half kept |
| wr_addr | output | ADDR_W | Capture write address |
| in_sel | output | 2 | Buffer index in the capture role |
| mid_sel | output | 2 | Buffer index in the work role |
| out_sel | output | 2 | Buffer index in the playback role |
| proc_start | output | 1 | One-cycle pulse: a new frame is ready for processing |
| proc_done | input | 1 | Processor finished the current frame |
| proc_addr | input | ADDR_W | Work-buffer word address |
| proc_we | input | 1 | Work-buffer write enable |
| proc_wdata | input | 16 | Work-buffer write data |
| proc_rdata | output | 16 | Work-buffer read data |
| out_ready | input | 1 | Downstream accepts the current playback word |
| out_valid | output | 1 | Playback word is presented |
| out_addr | output | ADDR_W | Playback read address |
| out_data | output | 16 | Playback word |
| overrun | output | 1 | Sticky flag: rotation came before `proc_done` |

## Verification
The processor's `proc_done` can arrive on the same edge as the final capture sample, which is also the rotation edge. The bench raises `proc_done` together with the last sample of a frame and expects `overrun` to stay low and a fresh `proc_start` to follow. A later frame then completes with no `proc_done` at all, and the bench expects the flag to rise, stay up after a late answer, and leave the rotation itself unaffected. Playback stalls with `out_ready` low, mixed with idle gaps in the sample stream, check that the capture and playback counters each move only on their own handshakes.

// File: rtl/tribuf_pkg.sv
package tribuf_pkg;

  localparam int NUM_BUFS = 3;

  typedef logic [1:0] buf_id_t;

  typedef struct packed {
    buf_id_t in_id;
    buf_id_t mid_id;
    buf_id_t out_id;
  } role_map_t;

  localparam role_map_t ROLE_RESET = '{in_id: 2'd0, mid_id: 2'd1, out_id: 2'd2};

  // Capture goes to work, work to playback, playback back to capture.
  function automatic role_map_t rotate_roles(input role_map_t cur);
    role_map_t nxt;
    nxt.in_id  = cur.out_id;
    nxt.mid_id = cur.in_id;
    nxt.out_id = cur.mid_id;
    return nxt;
  endfunction

endpackage

// File: rtl/tribuf_frame_store.sv
module tribuf_frame_store
  import tribuf_pkg::*;
#(
  parameter int FRAME_LEN = 128,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  buf_id_t           in_id,
  input  logic              in_we,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  buf_id_t           mid_id,
  input  logic [ADDR_W-1:0] mid_addr,
  input  logic              mid_we,
  input  logic [DATA_W-1:0] mid_wdata,
  output logic [DATA_W-1:0] mid_rdata,
  input  buf_id_t           out_id,
  input  logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_rdata
);

  logic [DATA_W-1:0] mid_rd_bank [NUM_BUFS];
  logic [DATA_W-1:0] out_rd_bank [NUM_BUFS];

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [FRAME_LEN];
    logic              bank_we;
    logic [ADDR_W-1:0] bank_wa;
    logic [DATA_W-1:0] bank_wd;

    // Capture and work roles never share a bank, so at most one port hits.
    always_comb begin
      bank_we = 1'b0;
      bank_wa = '0;
      bank_wd = '0;
      if (in_we && (in_id == buf_id_t'(b))) begin
        bank_we = 1'b1;
        bank_wa = in_addr;
        bank_wd = in_wdata;
      end else if (mid_we && (mid_id == buf_id_t'(b))) begin
        bank_we = 1'b1;
        bank_wa = mid_addr;
        bank_wd = mid_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < FRAME_LEN; i++) mem[i] <= '0;
      end else if (bank_we) begin
        mem[bank_wa] <= bank_wd;
      end
    end

    assign mid_rd_bank[b] = mem[mid_addr];
    assign out_rd_bank[b] = mem[out_addr];
  end

  always_comb begin
    mid_rdata = '0;
    out_rdata = '0;
    for (int b = 0; b < NUM_BUFS; b++) begin
      if (mid_id == buf_id_t'(b)) mid_rdata = mid_rd_bank[b];
      if (out_id == buf_id_t'(b)) out_rdata = out_rd_bank[b];
    end
  end

endmodule

// File: rtl/tribuf_fill_ctrl.sv
module tribuf_fill_ctrl
  import tribuf_pkg::*;
#(
  parameter int FRAME_LEN = 128,
  parameter int ADDR_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_ok,
  output logic [ADDR_W-1:0] wr_idx,
  output role_map_t         roles,
  output logic              rotate
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(FRAME_LEN - 1);

  logic [ADDR_W-1:0] wr_idx_q, wr_idx_d;
  role_map_t         roles_q, roles_d;

  always_comb begin
    rotate   = sample_ok && (wr_idx_q == LAST);
    wr_idx_d = wr_idx_q;
    roles_d  = roles_q;
    if (sample_ok) begin
      wr_idx_d = rotate ? '0 : wr_idx_q + 1'b1;
    end
    if (rotate) begin
      roles_d = rotate_roles(roles_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      roles_q  <= ROLE_RESET;
    end else begin
      wr_idx_q <= wr_idx_d;
      roles_q  <= roles_d;
    end
  end

  assign wr_idx = wr_idx_q;
  assign roles  = roles_q;

endmodule

// File: rtl/tribuf_proc_sync.sv
module tribuf_proc_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rotate,
  input  logic proc_done,
  output logic proc_start,
  output logic overrun
);

  logic busy_q, busy_d;
  logic start_q, start_d;
  logic ovr_q, ovr_d;

  always_comb begin
    busy_d  = busy_q;
    if (proc_done) busy_d = 1'b0;
    if (rotate)    busy_d = 1'b1;
    start_d = rotate;
    ovr_d   = ovr_q | (rotate & busy_q & ~proc_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      start_q <= start_d;
      ovr_q   <= ovr_d;
    end
  end

  assign proc_start = start_q;
  assign overrun    = ovr_q;

endmodule

// File: rtl/tribuf_drain.sv
module tribuf_drain #(
  parameter int FRAME_LEN = 128,
  parameter int ADDR_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rotate,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] rd_idx
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(FRAME_LEN - 1);

  logic              active_q, active_d;
  logic [ADDR_W-1:0] idx_q, idx_d;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    if (rotate) begin
      active_d = 1'b1;
      idx_d    = '0;
    end else if (active_q && out_ready) begin
      if (idx_q == LAST) begin
        active_d = 1'b0;
        idx_d    = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
    end
  end

  assign out_valid = active_q;
  assign rd_idx    = idx_q;

endmodule

// File: rtl/tribuf_rotator.sv
module tribuf_rotator
  import tribuf_pkg::*;
#(
  parameter int FRAME_LEN = 128,
  parameter int SAMPLE_W  = 32,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [1:0]        in_sel,
  output logic [1:0]        mid_sel,
  output logic [1:0]        out_sel,
  output logic              proc_start,
  input  logic              proc_done,
  input  logic [ADDR_W-1:0] proc_addr,
  input  logic              proc_we,
  input  logic [DATA_W-1:0] proc_wdata,
  output logic [DATA_W-1:0] proc_rdata,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              overrun
);

  // Reset asserts at once and is released two edges later.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  role_map_t         roles;
  logic              rotate;
  logic [DATA_W-1:0] kept_half;
  logic              unused_low_half;

  assign kept_half       = in_data[SAMPLE_W-1 -: DATA_W];
  assign unused_low_half = ^in_data[SAMPLE_W-DATA_W-1:0];

  tribuf_fill_ctrl #(
    .FRAME_LEN(FRAME_LEN),
    .ADDR_W   (ADDR_W)
  ) u_fill (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sample_ok(in_valid),
    .wr_idx   (wr_addr),
    .roles    (roles),
    .rotate   (rotate)
  );

  tribuf_proc_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rotate    (rotate),
    .proc_done (proc_done),
    .proc_start(proc_start),
    .overrun   (overrun)
  );

  tribuf_drain #(
    .FRAME_LEN(FRAME_LEN),
    .ADDR_W   (ADDR_W)
  ) u_drain (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rotate   (rotate),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .rd_idx   (out_addr)
  );

  tribuf_frame_store #(
    .FRAME_LEN(FRAME_LEN),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_id    (roles.in_id),
    .in_we    (in_valid),
    .in_addr  (wr_addr),
    .in_wdata (kept_half),
    .mid_id   (roles.mid_id),
    .mid_addr (proc_addr),
    .mid_we   (proc_we),
    .mid_wdata(proc_wdata),
    .mid_rdata(proc_rdata),
    .out_id   (roles.out_id),
    .out_addr (out_addr),
    .out_rdata(out_data)
  );

  assign in_sel  = roles.in_id;
  assign mid_sel = roles.mid_id;
  assign out_sel = roles.out_id;

endmodule

// File: rtl/tribuf_rotator_chk.sv
module tribuf_rotator_chk #(
  parameter int FRAME_LEN = 128,
  parameter int ADDR_W    = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [1:0]        in_sel,
  input logic [1:0]        mid_sel,
  input logic [1:0]        out_sel,
  input logic              proc_start,
  input logic              overrun,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(FRAME_LEN - 1);

  logic rot;
  assign rot = in_valid && (wr_addr == LAST);

  AST_ROLES_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sel != mid_sel) && (in_sel != out_sel) && (mid_sel != out_sel) &&
    (in_sel != 2'd3) && (mid_sel != 2'd3) && (out_sel != 2'd3)); // R2

  AST_ROTATE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    rot |=> (in_sel == $past(out_sel)) && (mid_sel == $past(in_sel)) &&
            (out_sel == $past(mid_sel))); // R2

  AST_ROLES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rot |=> $stable(in_sel) && $stable(mid_sel) && $stable(out_sel)); // R2

  AST_WADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(wr_addr)); // R3

  AST_WADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    rot |=> (wr_addr == '0)); // R3

  AST_START_AFTER_ROT: assert property (@(posedge clk) disable iff (!rst_n)
    rot |=> proc_start); // R6

  AST_START_ONLY_AFTER_ROT: assert property (@(posedge clk) disable iff (!rst_n)
    !rot |=> !proc_start); // R6

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R8

  AST_DRAIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    rot |=> out_valid && (out_addr == '0)); // R7

  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !rot) |=> out_valid && $stable(out_addr)); // R7

endmodule

bind tribuf_rotator tribuf_rotator_chk #(
  .FRAME_LEN(FRAME_LEN),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .wr_addr   (wr_addr),
  .in_sel    (in_sel),
  .mid_sel   (mid_sel),
  .out_sel   (out_sel),
  .proc_start(proc_start),
  .overrun   (overrun),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr)
);

// File: tb/tribuf_rotator_tb.sv
`timescale 1ns/1ps
module tribuf_rotator_tb;

  localparam int L  = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [31:0]   in_data;
  logic [AW-1:0] wr_addr;
  logic [1:0]    in_sel, mid_sel, out_sel;
  logic          proc_start, proc_done, proc_we;
  logic [AW-1:0] proc_addr;
  logic [15:0]   proc_wdata, proc_rdata;
  logic          out_ready, out_valid;
  logic [AW-1:0] out_addr;
  logic [15:0]   out_data;
  logic          overrun;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  tribuf_rotator #(.FRAME_LEN(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .wr_addr(wr_addr), .in_sel(in_sel), .mid_sel(mid_sel), .out_sel(out_sel),
    .proc_start(proc_start), .proc_done(proc_done), .proc_addr(proc_addr),
    .proc_we(proc_we), .proc_wdata(proc_wdata), .proc_rdata(proc_rdata),
    .out_ready(out_ready), .out_valid(out_valid), .out_addr(out_addr),
    .out_data(out_data), .overrun(overrun)
  );

  localparam logic [31:0] FA [L] = '{
    32'h1234_ABCD, 32'h8000_0001, 32'h7FFF_FFFF, 32'h0001_0000,
    32'hFFFF_1111, 32'hC350_2222, 32'h0000_FFFF, 32'h5A5A_A5A5};

  // {valid, frame word index, expected wr_addr after edge, expected start}
  localparam logic [7:0] TAB [12] = '{
    {1'b1, 3'd0, 3'd1, 1'b0}, {1'b1, 3'd1, 3'd2, 1'b0},
    {1'b0, 3'd0, 3'd2, 1'b0}, {1'b1, 3'd2, 3'd3, 1'b0},
    {1'b1, 3'd3, 3'd4, 1'b0}, {1'b0, 3'd0, 3'd4, 1'b0},
    {1'b1, 3'd4, 3'd5, 1'b0}, {1'b1, 3'd5, 3'd6, 1'b0},
    {1'b0, 3'd0, 3'd6, 1'b0}, {1'b1, 3'd6, 3'd7, 1'b0},
    {1'b1, 3'd7, 3'd0, 1'b1}, {1'b0, 3'd0, 3'd0, 1'b0}};

  function automatic logic [31:0] fb(input int i);
    return {16'hF000 + 16'(i) * 16'h0123, 16'h5555};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input logic [31:0] w);
    in_valid = 1'b1;
    in_data  = w;
    step();
    in_valid = 1'b0;
  endtask

  task automatic check_sels(input string tag, input logic [1:0] a, input logic [1:0] b, input logic [1:0] c);
    check({tag, " in_sel"},  {30'd0, in_sel},  {30'd0, a});
    check({tag, " mid_sel"}, {30'd0, mid_sel}, {30'd0, b});
    check({tag, " out_sel"}, {30'd0, out_sel}, {30'd0, c});
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; proc_done = 1'b0;
    proc_addr = '0; proc_we = 1'b0; proc_wdata = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_sels("R1 reset", 2'd0, 2'd1, 2'd2);
    check("R1 start",   {31'd0, proc_start}, 32'd0);
    check("R1 overrun", {31'd0, overrun},    32'd0);
    check("R1 valid",   {31'd0, out_valid},  32'd0);
    check("R1 wr_addr", {29'd0, wr_addr},    32'd0);
    rst_n = 1'b1;
    repeat (3) step();
    for (int i = 0; i < L; i++) begin
      proc_addr = AW'(i); #1;
      check("R1 cleared work word", {16'd0, proc_rdata}, 32'd0);
    end

    // R3 R6 table walk: frame A with idle gaps
    for (int k = 0; k < 12; k++) begin
      in_valid = TAB[k][7];
      in_data  = TAB[k][7] ? FA[TAB[k][6:4]] : 32'hDEAD_BEEF;
      step();
      check("R3 wr_addr", {29'd0, wr_addr}, {29'd0, TAB[k][3:1]});
      check("R6 start",   {31'd0, proc_start}, {31'd0, TAB[k][0]});
      if (k == 10) begin
        check_sels("R2 rotation 1", 2'd2, 2'd0, 2'd1);
        check("R7 valid after rotation", {31'd0, out_valid}, 32'd1);
      end
    end
    in_valid = 1'b0;

    // R4 R5 captured frame visible on the work port
    for (int i = 0; i < L; i++) begin
      proc_addr = AW'(i); #1;
      check("R4 stored upper half", {16'd0, proc_rdata}, {16'd0, FA[i][31:16]});
    end
    proc_addr = '0;
    for (int i = 0; i < 3; i++) begin
      put(fb(i));
      check("R5 work frame untouched by capture", {16'd0, proc_rdata}, {16'd0, FA[0][31:16]});
    end
    for (int i = 0; i < L; i++) begin
      proc_we = 1'b1; proc_addr = AW'(i); proc_wdata = ~FA[i][31:16];
      step();
    end
    proc_we = 1'b0; proc_addr = 3'd5; #1;
    check("R5 processor write", {16'd0, proc_rdata}, {16'd0, ~FA[5][31:16]});

    // R7 drain of the cleared playback buffer with a stall
    check("R7 addr start", {29'd0, out_addr}, 32'd0);
    step();
    check("R7 stall holds addr", {29'd0, out_addr}, 32'd0);
    out_ready = 1'b1;
    for (int i = 0; i < L; i++) begin
      check("R7 drain addr", {29'd0, out_addr}, i);
      check("R1 drain cleared word", {16'd0, out_data}, 32'd0);
      step();
    end
    out_ready = 1'b0;
    check("R7 valid low after last", {31'd0, out_valid}, 32'd0);

    // finish frame B after the processor answers
    proc_done = 1'b1; step(); proc_done = 1'b0;
    for (int i = 3; i < L; i++) put(fb(i));
    check_sels("R2 rotation 2", 2'd1, 2'd2, 2'd0);
    check("R8 no overrun when done early", {31'd0, overrun}, 32'd0);
    check("R6 start rotation 2", {31'd0, proc_start}, 32'd1);
    step();
    check("R6 start one cycle", {31'd0, proc_start}, 32'd0);

    // R7 ordered playback of processed frame with toggling ready
    for (int i = 0; i < L; i++) begin
      out_ready = 1'b0; step();
      check("R7 stall addr", {29'd0, out_addr}, i);
      out_ready = 1'b1;
      check("R7 processed word", {16'd0, out_data}, {16'd0, ~FA[i][31:16]});
      step();
    end
    out_ready = 1'b0;
    check("R7 valid low after frame", {31'd0, out_valid}, 32'd0);

    // R8 done coincides with the rotation edge
    for (int i = 0; i < L; i++) begin
      if (i == L - 1) proc_done = 1'b1;
      put(32'h0100_0000 * i);
      proc_done = 1'b0;
    end
    check_sels("R2 rotation 3", 2'd0, 2'd1, 2'd2);
    check("R8 coincident done no overrun", {31'd0, overrun}, 32'd0);
    check("R6 start rotation 3", {31'd0, proc_start}, 32'd1);
    out_ready = 1'b1;
    for (int i = 0; i < L; i++) begin
      check("R4 playback of raw frame B", {16'd0, out_data}, {16'd0, fb(i)[31:16]});
      step();
    end
    out_ready = 1'b0;

    // R8 no answer before the next rotation
    for (int i = 0; i < L; i++) put(32'h0);
    check("R8 overrun set", {31'd0, overrun}, 32'd1);
    check_sels("R2 rotation proceeds on overrun", 2'd2, 2'd0, 2'd1);
    check("R6 start despite overrun", {31'd0, proc_start}, 32'd1);
    proc_done = 1'b1; step(); proc_done = 1'b0; step();
    check("R8 overrun sticky", {31'd0, overrun}, 32'd1);

    finish_run();
  end

endmodule